// File: doc/BRIEF.md
# Scanline Counter Interrupt Generator

The block keeps an 8-bit line counter for a 256-line frame. It advances by one on every line strobe and rolls over from 255 to 0. Two periodic interrupt sources come straight from the counter bits:

- a square wave, which is counter bit 5 and changes level every 32 lines;
- a bottom-of-frame level, which is the AND of the upper four counter bits and is high for lines 240 to 255.

Each source feeds its own edge-detecting interrupt port. A port latches a flag when its input shows the selected edge. Per-port enable bits gate the flags into one active-high CPU interrupt.

A CPU reaches the block through a small register port. It can read a coarse copy of the counter with the two low bits forced to zero. For each port it can read and write a control byte, and it can read a data byte. Reading a port's data byte acknowledges that port's interrupt. This is the usual use: enable the sources it wants, take the interrupt, read the port's data byte to clear it, then read the counter to learn where the beam is.

Top module: `scan_irq_gen`

## Requirements
- R1: The line counter increments by exactly one on each cycle with `line_stb` high, holds otherwise, and wraps from 255 to 0.
- R2: Reading select code 0 returns the line counter with bits 1:0 forced to zero.
- R3: The square-wave source equals counter bit 5. With rising edge selected, port B's flag sets when the counter reaches line 32 (and every 64 lines after that).
- R4: The bottom source is high for lines 240 to 255 and low otherwise. Bit 0 of port A's data byte (select 1) shows its level, and with rising edge selected port A's flag sets at line 240.
- R5: A flag sets on its selected edge whether or not its enable bit is set. `irq` is the OR over both ports of flag AND enable, where enable is control bit 0.
- R6: A read strobe on a port's data byte clears that port's flag and leaves the other port's flag unchanged. Port A data is select 1 and port B data is select 3.
- R7: Control bit 1 selects the active edge: 1 means rising and 0 means falling. An edge of the other polarity leaves the flag clear.
- R8: Writing a control byte (port A at select 2, port B at select 4) stores bits 5:0. On read, bit 7 returns the port's flag and bit 6 returns zero, and writes to bits 7:6 are ignored.
- R9: When an edge and a data-byte read of the same port fall in one cycle, the flag ends up set.
- R10: After reset the counter, both control bytes, both flags and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_stb | input | 1 | One-cycle pulse per scanline |
| reg_sel | input | 3 | Register select code |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears flag on data bytes) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on `reg_sel` |
| irq | output | 1 | Active-high CPU interrupt |

## Verification
The line that produces a flag edge and the CPU read that acknowledges the same port can land in the same clock cycle. The bench provokes this by stepping the counter from 127 to 128 and then driving the port B data read in the very next cycle. That cycle is the one in which the edge detector sees bit 5 fall.

The flag and `irq` must both read as set afterwards, which shows the set has priority over the clear. A second read must then clear the flag, which shows that the set was real and not a stale value.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

   localparam int REG_W  = 8;
   localparam int CFG_W  = 6;
   localparam int NPORTS = 2;

   typedef enum logic [2:0] {
      SEL_VIEW   = 3'd0,
      SEL_A_DATA = 3'd1,
      SEL_A_CTRL = 3'd2,
      SEL_B_DATA = 3'd3,
      SEL_B_CTRL = 3'd4
   } reg_sel_e;

   localparam int CTL_EN    = 0;
   localparam int CTL_EDGE  = 1;
   localparam int CTL_FLAG1 = 7;
   localparam int CTL_FLAG2 = 6;

   typedef logic [CFG_W-1:0] port_cfg_t;

endpackage

// File: rtl/scan_line_counter.sv
module scan_line_counter #(
   parameter int LINE_W   = 8,
   parameter int SQ_BIT   = 5,
   parameter int TOP_BITS = 4,
   parameter bit SRC_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_stb,
   output logic [LINE_W-1:0] cnt,
   output logic              src_sq,
   output logic              src_top
);

   localparam int TOP_LO = LINE_W - TOP_BITS;
   localparam logic [LINE_W-1:0] TOP_LINE = {{TOP_BITS{1'b1}}, {TOP_LO{1'b0}}};

   generate
      if (LINE_W < 2 || SQ_BIT >= LINE_W) begin : g_bad_sq
         $error("scan_line_counter: SQ_BIT must lie inside the counter");
      end
      if (TOP_BITS < 1 || TOP_BITS >= LINE_W) begin : g_bad_top
         $error("scan_line_counter: TOP_BITS out of range");
      end
   endgenerate

   logic sq_raw;
   logic top_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (line_stb) cnt <= cnt + 1'b1;
   end

   assign sq_raw  = cnt[SQ_BIT];
   assign top_raw = &cnt[LINE_W-1:TOP_LO];

   generate
      if (SRC_REG) begin : g_src_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               src_sq  <= 1'b0;
               src_top <= 1'b0;
            end else begin
               src_sq  <= sq_raw;
               src_top <= top_raw;
            end
         end
      end else begin : g_src_comb
         assign src_sq  = sq_raw;
         assign src_top = top_raw;

         AST_TOP_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
            src_top == (cnt >= TOP_LINE)); // R4
      end
   endgenerate

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      line_stb |=> cnt == $past(cnt) + 1'b1); // R1
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !line_stb |=> $stable(cnt)); // R1

endmodule

// File: rtl/scan_edge_port.sv
module scan_edge_port
   import scan_irq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      src,
   input  logic      cfg_wr,
   input  port_cfg_t cfg_wdata,
   input  logic      clr,
   output port_cfg_t cfg,
   output logic      flag,
   output logic      req,
   output logic      level
);

   logic prev;
   logic edge_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg <= '0;
      else if (cfg_wr) cfg <= cfg_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= src;
   end

   assign edge_hit = cfg[CTL_EDGE] ? (src & ~prev) : (~src & prev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (edge_hit) flag <= 1'b1;
      else if (clr)      flag <= 1'b0;
   end

   assign req   = flag & cfg[CTL_EN];
   assign level = src;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |=> flag); // R9
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !edge_hit) |=> !flag); // R6
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !edge_hit) |=> $stable(flag)); // R5

endmodule

// File: rtl/scan_irq_gen.sv
module scan_irq_gen
   import scan_irq_pkg::*;
#(
   parameter int LINE_W    = 8,
   parameter int SQ_BIT    = 5,
   parameter int TOP_BITS  = 4,
   parameter int VIEW_DROP = 2,
   parameter bit SRC_REG   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_stb,
   input  logic [2:0]       reg_sel,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             irq
);

   localparam logic [LINE_W-1:0] VIEW_MASK = ~{{(LINE_W-VIEW_DROP){1'b0}}, {VIEW_DROP{1'b1}}};

   generate
      if (LINE_W > REG_W) begin : g_bad_w
         $error("scan_irq_gen: counter wider than register port");
      end
      if (VIEW_DROP < 1 || VIEW_DROP >= LINE_W) begin : g_bad_drop
         $error("scan_irq_gen: VIEW_DROP out of range");
      end
   endgenerate

   logic [LINE_W-1:0] cnt;
   logic              src_sq;
   logic              src_top;
   logic [NPORTS-1:0] src_v;
   logic [NPORTS-1:0] flag_v;
   logic [NPORTS-1:0] req_v;
   logic [NPORTS-1:0] lvl_v;
   logic [NPORTS-1:0] wr_v;
   logic [NPORTS-1:0] clr_v;
   port_cfg_t         cfg_v [NPORTS];

   scan_line_counter #(
      .LINE_W  (LINE_W),
      .SQ_BIT  (SQ_BIT),
      .TOP_BITS(TOP_BITS),
      .SRC_REG (SRC_REG)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_stb(line_stb),
      .cnt     (cnt),
      .src_sq  (src_sq),
      .src_top (src_top)
   );

   // port 0 (A) watches the bottom zone, port 1 (B) the square wave
   assign src_v = {src_sq, src_top};

   genvar gi;
   generate
      for (gi = 0; gi < NPORTS; gi++) begin : g_port
         localparam logic [2:0] DATA_SEL = 3'(1 + 2*gi);
         localparam logic [2:0] CTRL_SEL = 3'(2 + 2*gi);

         assign wr_v[gi]  = reg_wr && (reg_sel == CTRL_SEL);
         assign clr_v[gi] = reg_rd && (reg_sel == DATA_SEL);

         scan_edge_port u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (src_v[gi]),
            .cfg_wr   (wr_v[gi]),
            .cfg_wdata(reg_wdata[CFG_W-1:0]),
            .clr      (clr_v[gi]),
            .cfg      (cfg_v[gi]),
            .flag     (flag_v[gi]),
            .req      (req_v[gi]),
            .level    (lvl_v[gi])
         );
      end
   endgenerate

   assign irq = |req_v;

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_VIEW:   reg_rdata[LINE_W-1:0] = cnt & VIEW_MASK;
         SEL_A_DATA: reg_rdata[0] = lvl_v[0];
         SEL_A_CTRL: reg_rdata = {flag_v[0], 1'b0, cfg_v[0]};
         SEL_B_DATA: reg_rdata[0] = lvl_v[1];
         SEL_B_CTRL: reg_rdata = {flag_v[1], 1'b0, cfg_v[1]};
         default:    reg_rdata = '0;
      endcase
   end

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_v[0][CTL_EN] && !cfg_v[1][CTL_EN]) |-> !irq); // R5
   AST_VIEW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == SEL_VIEW) |-> (reg_rdata[VIEW_DROP-1:0] == '0)); // R2
   AST_FLAG2_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == SEL_A_CTRL || reg_sel == SEL_B_CTRL) |-> !reg_rdata[CTL_FLAG2]); // R8

endmodule

// File: tb/tb_scan_irq_gen.sv
`timescale 1ns/1ps
module tb_scan_irq_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_stb = 1'b0;
   logic [2:0] reg_sel = 3'd0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   scan_irq_gen dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_stb (line_stb),
      .reg_sel  (reg_sel),
      .reg_wr   (reg_wr),
      .reg_rd   (reg_rd),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .irq      (irq)
   );

   // {lines to advance, expected counter view, flag A, flag B}
   localparam logic [18:0] VEC_TAB [0:5] = '{
      {9'd3,   8'h00, 1'b0, 1'b0},
      {9'd29,  8'h20, 1'b0, 1'b1},
      {9'd5,   8'h24, 1'b0, 1'b1},
      {9'd203, 8'hF0, 1'b1, 1'b1},
      {9'd15,  8'hFC, 1'b1, 1'b1},
      {9'd1,   8'h00, 1'b1, 1'b1}
   };

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic peek(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_sel = a;
      #1 v = reg_rdata;
   endtask

   task automatic peek_irq(output logic v);
      @(negedge clk);
      #1 v = irq;
   endtask

   task automatic cpu_read(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_sel = a;
      reg_rd = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic cpu_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_sel = a;
      reg_wdata = d;
      reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic advance(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         line_stb = 1'b1;
         @(negedge clk);
         line_stb = 1'b0;
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic       q;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      peek(3'd0, v); chk("R10 view", v, 8'h00);
      peek(3'd2, v); chk("R10 ctrl A", v, 8'h00);
      peek(3'd4, v); chk("R10 ctrl B", v, 8'h00);
      peek_irq(q);   chk("R10 irq", {7'd0, q}, 8'h00);

      // rising edge on both ports, enables off
      cpu_write(3'd2, 8'h02);
      cpu_write(3'd4, 8'h02);

      // R1 R2 R3 R4 R5 vector walk
      for (int i = 0; i < 6; i++) begin
         advance(int'(VEC_TAB[i][18:10]));
         peek(3'd0, v); chk("R1 R2 view", v, VEC_TAB[i][9:2]);
         peek(3'd2, v); chk("R4 flag A", {7'd0, v[7]}, {7'd0, VEC_TAB[i][1]});
         peek(3'd4, v); chk("R3 flag B", {7'd0, v[7]}, {7'd0, VEC_TAB[i][0]});
         peek_irq(q);   chk("R5 irq masked", {7'd0, q}, 8'h00);
      end

      // R6 acknowledge one port at a time
      cpu_read(3'd1, v);
      peek(3'd2, v); chk("R6 A cleared", {7'd0, v[7]}, 8'h00);
      peek(3'd4, v); chk("R6 B kept", {7'd0, v[7]}, 8'h01);
      cpu_read(3'd3, v);
      peek(3'd4, v); chk("R6 B cleared", {7'd0, v[7]}, 8'h00);

      // R5 enabled rising on port B, counter at 0
      cpu_write(3'd4, 8'h03);
      peek_irq(q); chk("R5 irq idle", {7'd0, q}, 8'h00);
      advance(32);
      peek_irq(q); chk("R5 irq on edge", {7'd0, q}, 8'h01);
      cpu_read(3'd3, v);
      peek_irq(q); chk("R5 irq after ack", {7'd0, q}, 8'h00);

      // R7 falling edge select
      cpu_write(3'd4, 8'h01);
      advance(32); // line 64, bit 5 falls
      peek_irq(q); chk("R7 falling edge", {7'd0, q}, 8'h01);
      cpu_read(3'd3, v);
      advance(32); // line 96, bit 5 rises
      peek_irq(q); chk("R7 rising ignored", {7'd0, q}, 8'h00);
      peek(3'd4, v); chk("R7 flag clear", {7'd0, v[7]}, 8'h00);

      // R9 edge and acknowledge in the same cycle
      advance(31); // line 127
      @(negedge clk);
      line_stb = 1'b1;
      @(negedge clk);
      line_stb = 1'b0;
      reg_sel = 3'd3;
      reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      peek(3'd4, v); chk("R9 set wins", {7'd0, v[7]}, 8'h01);
      peek_irq(q);   chk("R9 irq", {7'd0, q}, 8'h01);
      cpu_read(3'd3, v);
      peek(3'd4, v); chk("R9 later clear", {7'd0, v[7]}, 8'h00);

      // R8 control read/write layout
      cpu_write(3'd2, 8'hFF);
      peek(3'd2, v); chk("R8 ctrl A bits", v, 8'h3F);
      cpu_write(3'd2, 8'h02);
      peek(3'd2, v); chk("R8 ctrl A back", v, 8'h02);

      // R4 level window, counter at 128
      advance(111); // line 239
      peek(3'd1, v); chk("R4 level 239", v, 8'h00);
      advance(1);
      peek(3'd1, v); chk("R4 level 240", v, 8'h01);
      advance(15);
      peek(3'd1, v); chk("R4 level 255", v, 8'h01);
      advance(1);
      peek(3'd1, v); chk("R4 level 0", v, 8'h00);
      peek(3'd0, v); chk("R1 wrap", v, 8'h00);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule